// File: doc/BRIEF.md
# Key-Guarded Configuration Register Bank

This block holds a small set of memory-mapped configuration registers behind a write-protection lock. A simple word-addressed register bus (address, write strobe, write data, registered read data) reaches two key registers, one writable boot address register per processor core, and one read-only register that captures the local-reset and non-maskable-interrupt pins of every core. Reads are permitted at all times. Configuration writes are honoured only while the bank is unlocked.

The bank leaves reset locked. Software opens it by writing the first magic word to the first key register and then the second magic word to the second key register. Writing any other value to either key register closes the bank immediately. The boot address registers drive a flat output vector that the per-core fetch logic can use.

The word address map is: 0 first key, 1 second key, 2 pin status, and `BOOT_BASE + n` (8 by default) for the boot address of core n. All other addresses are unmapped.

Top module: `cfg_keybank`

## Requirements
- R1: After reset the bank is locked, every boot address register reads 0x20B00000, and the pin status register reads zero.
- R2: Writing 0x83E70B13 to word 0 and then 0x95A4F1E0 to word 1 unlocks the bank. After that, writes to boot address registers take effect on the next clock edge.
- R3: Writing the correct second key while the first key has not been accepted leaves the bank locked. A first-key write that follows does not open it on its own.
- R4: A write of any value other than its magic value to either key register locks the bank at once, whatever the lock state was.
- R5: While the bank is locked, a write to a boot address register is dropped and the register keeps its value.
- R6: Each boot address register stores write-data bits 31:10. Bits 9:0 always read as zero and ignore writes.
- R7: The pin status register is read-only. Bits 7:0 hold the local-reset pins, bits 15:8 hold the NMI pins, and bits 31:16 are zero, each sampled one clock before the read. Writes to it have no effect even while unlocked.
- R8: Both key registers read back as zero.
- R9: Once unlocked, the bank stays unlocked across any number of configuration, unmapped and correct-key writes, until a wrong key write or a reset.
- R10: A write to an unmapped address changes nothing, and a read from one returns zero.
- R11: Read data appears on `bus_rdata` one clock after the address is presented. The `boot_addr` output reflects each boot register one clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| lrst_pin | input | N_CORES | Local-reset pin per core |
| nmi_pin | input | N_CORES | NMI pin per core |
| boot_addr | output | N_CORES*DATA_W | Boot address of each core, core 0 in the low word |

## Verification
The bench goes through every ordered pair of key writes (good or bad, first or second key) starting from the locked state. A design that opens on the second key alone, or that ignores write order, would let a later boot write through. Every boot register is swept with several data patterns while locked and while unlocked, which catches writes that leak while locked and reserved low bits that get stored. The bench also walks all 256 pin patterns and the whole unmapped address range, so it detects a status register that accepts writes, mis-ordered pin fields, or aliasing that lets an unmapped write reach a real register. It also checks that the bank relocks after a wrong key written while unlocked and after a mid-run reset.

// File: rtl/cfgkb_pkg.sv
package cfgkb_pkg;

  // Lock progress: the first key must be accepted before the second can open the bank.
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } kick_st_e;

  localparam logic [31:0] MAGIC_FIRST  = 32'h83E7_0B13;
  localparam logic [31:0] MAGIC_SECOND = 32'h95A4_F1E0;
  localparam logic [31:0] BOOT_RESET   = 32'h20B0_0000;

endpackage

// File: rtl/cfgkb_lock.sv
module cfgkb_lock
  import cfgkb_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = MAGIC_FIRST[DATA_W-1:0],
  parameter logic [DATA_W-1:0] KEY_B = MAGIC_SECOND[DATA_W-1:0],
  parameter logic [ADDR_W-1:0] A_KEY_A = '0,
  parameter logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output kick_st_e          st_o,
  output logic              open_o
);

  kick_st_e st_q;
  kick_st_e st_d;

  always_comb begin
    st_d = st_q;
    if (we && addr == A_KEY_A) begin
      if (wdata != KEY_A)          st_d = KS_LOCKED;
      else if (st_q != KS_OPEN)    st_d = KS_HALF;
    end else if (we && addr == A_KEY_B) begin
      if (wdata != KEY_B)          st_d = KS_LOCKED;
      else if (st_q == KS_HALF)    st_d = KS_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= KS_LOCKED;
    else     st_q <= st_d;
  end

  assign st_o   = st_q;
  assign open_o = (st_q == KS_OPEN);

endmodule

// File: rtl/cfgkb_bootregs.sv
module cfgkb_bootregs #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int N_CORES   = 8,
  parameter int BOOT_BASE = 8,
  parameter int BOOT_LSB  = 10,
  parameter logic [DATA_W-1:0] RST_VAL = 32'h20B0_0000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      open,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [N_CORES*DATA_W-1:0] boot_o
);

  localparam int FIELD_W = DATA_W - BOOT_LSB;
  localparam logic [FIELD_W-1:0] FIELD_RST = RST_VAL[DATA_W-1:BOOT_LSB];

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BOOT_BASE + i);
    logic [FIELD_W-1:0] fld_q;

    always_ff @(posedge clk) begin
      if (rst)                               fld_q <= FIELD_RST;
      else if (open && we && addr == MY_ADDR) fld_q <= wdata[DATA_W-1:BOOT_LSB];
    end

    assign boot_o[i*DATA_W +: DATA_W] = {fld_q, {BOOT_LSB{1'b0}}};
  end

endmodule

// File: rtl/cfgkb_pinstat.sv
module cfgkb_pinstat #(
  parameter int DATA_W  = 32,
  parameter int N_CORES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] lrst_i,
  input  logic [N_CORES-1:0] nmi_i,
  output logic [DATA_W-1:0]  stat_o
);

  localparam int USED_W = 2 * N_CORES;

  logic [DATA_W-1:0] stat_d;

  always_comb begin
    stat_d = '0;
    stat_d[N_CORES-1:0]      = lrst_i;
    stat_d[USED_W-1:N_CORES] = nmi_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= stat_d;
  end

endmodule

// File: rtl/cfg_keybank.sv
module cfg_keybank
  import cfgkb_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int N_CORES   = 8,
  parameter int BOOT_BASE = 8,
  parameter int BOOT_LSB  = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [N_CORES-1:0]        lrst_pin,
  input  logic [N_CORES-1:0]        nmi_pin,
  output logic [N_CORES*DATA_W-1:0] boot_addr
);

  localparam logic [ADDR_W-1:0] A_KEY_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KEY_B = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(2);

  kick_st_e          lock_st;
  logic              bank_open;
  logic [DATA_W-1:0] pin_stat;
  logic [DATA_W-1:0] rd_next;

  cfgkb_lock #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_A  (MAGIC_FIRST[DATA_W-1:0]),
    .KEY_B  (MAGIC_SECOND[DATA_W-1:0]),
    .A_KEY_A(A_KEY_A),
    .A_KEY_B(A_KEY_B)
  ) u_lock (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .st_o  (lock_st),
    .open_o(bank_open)
  );

  cfgkb_bootregs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .N_CORES  (N_CORES),
    .BOOT_BASE(BOOT_BASE),
    .BOOT_LSB (BOOT_LSB),
    .RST_VAL  (BOOT_RESET[DATA_W-1:0])
  ) u_boot (
    .clk   (clk),
    .rst   (rst),
    .open  (bank_open),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .boot_o(boot_addr)
  );

  cfgkb_pinstat #(
    .DATA_W (DATA_W),
    .N_CORES(N_CORES)
  ) u_pin (
    .clk   (clk),
    .rst   (rst),
    .lrst_i(lrst_pin),
    .nmi_i (nmi_pin),
    .stat_o(pin_stat)
  );

  // Keys and unmapped words fall through to zero.
  always_comb begin
    rd_next = '0;
    if (bus_addr == A_PIN) rd_next = pin_stat;
    for (int i = 0; i < N_CORES; i++) begin
      if (bus_addr == ADDR_W'(BOOT_BASE + i)) rd_next = boot_addr[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

endmodule

// File: rtl/cfgkb_checker.sv
module cfgkb_checker
  import cfgkb_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int N_CORES   = 8,
  parameter int BOOT_BASE = 8,
  parameter int BOOT_LSB  = 10
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [N_CORES*DATA_W-1:0] boot_addr,
  input kick_st_e                  lock_st,
  input logic                      bank_open
);

  localparam logic [ADDR_W-1:0] A_KEY_A   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KEY_B   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PIN     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BOOT_LO = ADDR_W'(BOOT_BASE);
  localparam logic [ADDR_W-1:0] A_BOOT_HI = ADDR_W'(BOOT_BASE + N_CORES - 1);
  localparam int USED_W = 2 * N_CORES;

  logic is_key, is_boot, is_mapped;
  assign is_key    = (bus_addr == A_KEY_A) || (bus_addr == A_KEY_B);
  assign is_boot   = (bus_addr >= A_BOOT_LO) && (bus_addr <= A_BOOT_HI);
  assign is_mapped = is_key || is_boot || (bus_addr == A_PIN);

  p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lock_st == KS_LOCKED);

  p_unlock_seq_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_KEY_B && bus_wdata == MAGIC_SECOND[DATA_W-1:0] && lock_st == KS_HALF)
    |=> bank_open);

  p_second_early_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_KEY_B && lock_st == KS_LOCKED) |=> lock_st == KS_LOCKED);

  p_bad_first_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_KEY_A && bus_wdata != MAGIC_FIRST[DATA_W-1:0]) |=> lock_st == KS_LOCKED);

  p_bad_second_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_KEY_B && bus_wdata != MAGIC_SECOND[DATA_W-1:0]) |=> lock_st == KS_LOCKED);

  p_locked_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bank_open) |=> $stable(boot_addr));

  p_resv_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) >= A_BOOT_LO && $past(bus_addr) <= A_BOOT_HI) |-> bus_rdata[BOOT_LSB-1:0] == '0);

  p_pin_upper_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_PIN) |-> bus_rdata[DATA_W-1:USED_W] == '0);

  p_key_read_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == A_KEY_A || $past(bus_addr) == A_KEY_B) |-> bus_rdata == '0);

  p_stay_open_r9: assert property (@(posedge clk) disable iff (rst)
    (bank_open && !(bus_we && is_key)) |=> bank_open);

  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !is_mapped) |=> $stable(boot_addr));

  p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(is_mapped)) |-> bus_rdata == '0);

endmodule

bind cfg_keybank cfgkb_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .N_CORES  (N_CORES),
  .BOOT_BASE(BOOT_BASE),
  .BOOT_LSB (BOOT_LSB)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .boot_addr(boot_addr),
  .lock_st  (lock_st),
  .bank_open(bank_open)
);

// File: tb/test_cfg_keybank.sv
`timescale 1ns/1ps
module test_cfg_keybank;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NC = 8;
  localparam int BB = 8;
  localparam logic [31:0] K1 = 32'h83E7_0B13;
  localparam logic [31:0] K2 = 32'h95A4_F1E0;
  localparam logic [31:0] BRST = 32'h20B0_0000;
  localparam logic [31:0] FMASK = 32'hFFFF_FC00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NC-1:0] lrst_pin = '0;
  logic [NC-1:0] nmi_pin = '0;
  logic [NC*DW-1:0] boot_addr;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_boot [NC];

  always #4 clk = ~clk;

  cfg_keybank i_cfg_keybank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lrst_pin(lrst_pin),
    .nmi_pin(nmi_pin), .boot_addr(boot_addr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Tasks begin and end just after a falling edge.
  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic check_boots(input string req);
    logic [31:0] v;
    for (int i = 0; i < NC; i++) begin
      rd(BB + i, v);
      chk(req, v, exp_boot[i]);
      chk(req, boot_addr[i*DW +: DW], exp_boot[i]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NC; i++) exp_boot[i] = BRST;
  endtask

  // kind: 0 good first key, 1 bad first key, 2 good second key, 3 bad second key
  task automatic key_write(input int kind);
    case (kind)
      0: wr(0, K1);
      1: wr(0, K1 ^ 32'h0000_0100);
      2: wr(1, K2);
      default: wr(1, 32'h0);
    endcase
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    @(negedge clk);
    do_reset();

    // R1 reset state, R8 key reads, R10 unmapped reads
    check_boots("R1");
    rd(2, v); chk("R1", v, 32'h0);
    rd(0, v); chk("R8", v, 32'h0);
    rd(1, v); chk("R8", v, 32'h0);
    for (int a = 3; a < BB; a++) begin rd(a, v); chk("R10", v, 32'h0); end
    for (int a = BB + NC; a < 64; a++) begin rd(a, v); chk("R10", v, 32'h0); end

    // R5 locked writes dropped, R3 second key alone does nothing
    for (int i = 0; i < NC; i++) wr(BB + i, 32'hDEAD_BEEF ^ i);
    check_boots("R5");
    wr(1, K2);
    wr(BB, 32'h1234_5678);
    check_boots("R3");

    // R2 R3 R4: every ordered pair of key writes from the locked state
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int idx;
        bit opens;
        idx = (a * 4 + b) % NC;
        wr(0, 32'h0);                   // force locked
        key_write(a);
        key_write(b);
        opens = (a == 0) && (b == 2);
        pat = 32'h5A00_0000 ^ (32'(a * 4 + b) << 12) ^ 32'h3FF;
        wr(BB + idx, pat);
        if (opens) exp_boot[idx] = pat & FMASK;
        rd(BB + idx, v);
        if (opens)       chk("R2", v, exp_boot[idx]);
        else if (b == 2) chk("R3", v, exp_boot[idx]);
        else             chk("R4", v, exp_boot[idx]);
      end
    end

    // R6 R9: unlock, sweep patterns over all boot registers
    wr(0, K1); wr(1, K2);
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < NC; i++) begin
        case (p)
          0: pat = 32'hFFFF_FFFF;
          1: pat = 32'h0;
          2: pat = 32'h5555_5555;
          3: pat = 32'hAAAA_AAAA;
          4: pat = 32'h1 << (i * 4);
          default: pat = ~(32'h400 << i);
        endcase
        wr(BB + i, pat);
        exp_boot[i] = pat & FMASK;
        chk("R11", boot_addr[i*DW +: DW], exp_boot[i]);
      end
      check_boots("R6");
    end

    // R10 R9: unmapped writes ignored and keep the bank open
    for (int a = 3; a < BB; a++) wr(a, 32'hFFFF_FFFF);
    for (int a = BB + NC; a < 64; a++) wr(a, 32'hFFFF_FFFF);
    check_boots("R10");
    rd(5, v); chk("R10", v, 32'h0);
    rd(63, v); chk("R10", v, 32'h0);
    wr(0, K1); wr(1, K2); wr(1, K2);   // correct keys while open
    wr(BB + 3, 32'h8765_4321); exp_boot[3] = 32'h8765_4321 & FMASK;
    rd(BB + 3, v); chk("R9", v, exp_boot[3]);
    rd(0, v); chk("R8", v, 32'h0);
    rd(1, v); chk("R8", v, 32'h0);

    // R7 pin status sweep, writes ignored while unlocked
    for (int p = 0; p < 256; p++) begin
      lrst_pin = 8'(p);
      nmi_pin  = 8'(p * 37 + 11);
      @(negedge clk);
      if (p % 64 == 0) wr(2, 32'hFFFF_FFFF);
      rd(2, v);
      chk("R7", v, {16'h0, 8'(p * 37 + 11), 8'(p)});
    end

    // R4 wrong key while open relocks
    wr(1, K2 + 1);
    wr(BB + 1, 32'h0);
    rd(BB + 1, v); chk("R4", v, exp_boot[1]);
    wr(0, K1); wr(1, K2);
    wr(0, 32'hFFFF_FFFF);
    wr(BB + 2, 32'h0);
    rd(BB + 2, v); chk("R4", v, exp_boot[2]);

    // R1 reset while open relocks and restores
    wr(0, K1); wr(1, K2);
    do_reset();
    check_boots("R1");
    wr(BB, 32'h0);
    rd(BB, v); chk("R1", v, BRST);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule